// File: doc/BRIEF.md
# Dual-Channel Serial ADC Readout Controller

This block is the system-side master for a two-input, 12-bit sampling converter that talks over a four-wire serial link. It pulls an active-low chip select low and produces a serial clock that is divided down from the system clock. Each frame has sixteen serial clocks. During a frame the block shifts in the converter's reply and shifts out the channel request for the next conversion. The reply holds three leading zero bits, a bit that names the converted channel, and then the 12 result bits with the most significant bit first.

Between frames the block keeps chip select high for a minimum quiet gap. It also waits for a programmable throughput period to expire before it starts another frame. This leaves the converter enough time to acquire the next input. The divider ratio and both counts are parameters given in system-clock cycles.

Software chooses between two modes. In scan mode the block alternates the two inputs on its own. In fixed mode it always requests the channel set by a control pin. Each finished frame is presented as a parallel result with a one-cycle valid strobe and a flag for a corrupted leading bit.

Top module: `adc2ch_reader`

## Requirements
- R1: Chip select stays low for exactly 33 × DIV_HALF system cycles per frame. The serial clock has exactly 16 rising edges in that window. The serial clock is high whenever chip select is high.
- R2: The first falling edge of the serial clock comes exactly DIV_HALF system cycles after chip select falls. Every later half period is also DIV_HALF cycles.
- R3: The input line is sampled on each rising edge of the serial clock. Reply bit 0 is the first one received. Bits 0 to 2 are leading zeros, bit 3 is the converted channel, and bits 4 to 15 are result bits 11 down to 0. These bits appear on `code_o` and `ch_o`.
- R4: `lead_err_o` is 1 with a result when any of reply bits 0 to 2 was 1. The code and channel of that frame are still reported.
- R5: `din_o` changes only on falling edges of the serial clock. It carries the requested channel in slot 2, which the converter samples on the third rising edge. It is 0 in every other slot and whenever chip select is high.
- R6: With `scan_i` = 1, the requested channel alternates from frame to frame. The first request after reset is channel 1.
- R7: With `scan_i` = 0, the request equals `fixed_ch_i`. Mode and channel are latched when a frame starts, so changing them in the middle of a frame has no effect on that frame's request.
- R8: `valid_o` is a one-cycle pulse that rises on the same clock edge where chip select returns high. The result outputs then hold their value until the next pulse.
- R9: While `run_i` stays high, consecutive chip-select falls are exactly max(PERIOD_CYC, 33 × DIV_HALF + QUIET_CYC) cycles apart. They are never closer than PERIOD_CYC.
- R10: Chip select stays high for at least QUIET_CYC cycles between frames.
- R11: The converter's output line has no effect on any result while chip select is high.
- R12: While `run_i` is low, no new frame starts. A frame already in progress runs to the end and delivers its result.
- R13: During reset and right after it, chip select and the serial clock are high, and `din_o`, `valid_o` and the result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | Allows new frames to start |
| scan_i | input | 1 | 1 = alternate channels, 0 = fixed channel |
| fixed_ch_i | input | 1 | Channel requested in fixed mode |
| dout_i | input | 1 | Serial reply from the converter |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| din_o | output | 1 | Serial request line to the converter |
| valid_o | output | 1 | One-cycle strobe for a new result |
| ch_o | output | 1 | Channel that produced the result |
| lead_err_o | output | 1 | A leading bit of the reply was non-zero |
| code_o | output | 12 | Conversion result |

## Verification
The assertions assume the converter changes its output only after a serial-clock falling edge and holds it through the following rising edge. They also assume the control inputs are synchronous to `clk`, and that DIV_HALF is at least 2 while QUIET_CYC and PERIOD_CYC are at least 1. The bench's converter model sees each falling edge and drives the next reply bit half a system cycle later, which leaves most of a half period before the sampling edge. It changes the control pins only on the inactive clock edge. Between frames it drives random values on the reply line, so any capture outside a frame would show up as a miscompare.

// File: rtl/adc2ch_pkg.sv
package adc2ch_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int FRAME_BITS   = 16;
    localparam int RES_W        = 12;
    localparam int LEAD_BITS    = 3;
    localparam int SEL_SLOT     = 2;
    localparam int HALF_PERIODS = 2 * FRAME_BITS + 1;
    localparam int BIT_CNT_W    = $clog2(FRAME_BITS + 1);

    typedef logic [FRAME_BITS-1:0] frame_word_t;

    typedef struct packed {
        logic             lead_err;
        logic             chan;
        logic [RES_W-1:0] code;
    } result_t;

    typedef enum logic {PH_IDLE, PH_FRAME} phase_t;

    // first received bit ends up at the top of the word
    function automatic result_t decode_frame(frame_word_t w);
        result_t r;
        r.lead_err = |w[FRAME_BITS-1 -: LEAD_BITS];
        r.chan     = w[RES_W];
        r.code     = w[RES_W-1:0];
        return r;
    endfunction

    function automatic logic pick_channel(logic scan, logic fixed_ch, logic prev);
        return scan ? ~prev : fixed_ch;
    endfunction
endpackage

// File: rtl/adc2ch_sclk_gen.sv
module adc2ch_sclk_gen #(
    parameter int DIV_HALF = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic park_i,
    output logic sclk_o,
    output logic fall_o,
    output logic rise_o
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CW = $clog2(DIV_HALF + 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap   = en_i && (cnt == CW'(DIV_HALF - 1));
    assign fall_o = wrap && sclk_o;
    assign rise_o = wrap && !sclk_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            sclk_o <= 1'b1;
        end else if (!en_i) begin
            cnt    <= '0;
            sclk_o <= 1'b1;
        end else if (wrap) begin
            cnt <= '0;
            if (!(sclk_o && park_i))
                sclk_o <= ~sclk_o;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R1: the clock parks high whenever the divider is stopped
    p_park_high_r1: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> sclk_o);
endmodule

// File: rtl/adc2ch_shifter.sv
module adc2ch_shifter
    import adc2ch_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        sel_i,
    input  logic        fall_i,
    input  logic        rise_i,
    input  logic        dout_i,
    output logic        din_o,
    output logic        last_o,
    output logic        done_o,
    output frame_word_t word_o
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [BIT_CNT_W-1:0] rcnt;
    logic                 sel_q;

    assign last_o = (rcnt == BIT_CNT_W'(FRAME_BITS));
    assign done_o = fall_i && last_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            rcnt   <= '0;
            sel_q  <= 1'b0;
            din_o  <= 1'b0;
            word_o <= '0;
        end else if (start_i) begin
            rcnt   <= '0;
            sel_q  <= sel_i;
            din_o  <= 1'b0;
            word_o <= '0;
        end else begin
            if (fall_i && !last_o)
                din_o <= (rcnt == BIT_CNT_W'(SEL_SLOT)) ? sel_q : 1'b0;
            if (rise_i && !last_o) begin
                word_o <= {word_o[FRAME_BITS-2:0], dout_i};
                rcnt   <= rcnt + 1'b1;
            end
        end
    end

    // R1: the clock generator never delivers a seventeenth sampling edge
    p_no_extra_rise_r1: assert property (@(posedge clk) disable iff (rst)
        rise_i |-> !last_o);
    // R5: the request line only moves right after a falling-edge strobe
    p_din_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(din_o) |-> ($past(fall_i) || $past(start_i)));
endmodule

// File: rtl/adc2ch_pacer.sv
module adc2ch_pacer #(
    parameter int QUIET_CYC  = 6,
    parameter int PERIOD_CYC = 800
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic end_i,
    output logic ready_o
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int PW = $clog2(PERIOD_CYC + 1);
    localparam int QW = $clog2(QUIET_CYC + 1);

    logic [PW-1:0] per_cnt;
    logic [QW-1:0] qt_cnt;

    assign ready_o = (per_cnt == '0) && (qt_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            per_cnt <= '0;
            qt_cnt  <= '0;
        end else begin
            if (start_i)
                per_cnt <= PW'(PERIOD_CYC - 1);
            else if (per_cnt != '0)
                per_cnt <= per_cnt - 1'b1;

            if (end_i)
                qt_cnt <= QW'(QUIET_CYC - 1);
            else if (qt_cnt != '0)
                qt_cnt <= qt_cnt - 1'b1;
        end
    end

    // R9: no frame starts before the throughput window has run out
    p_period_gap_r9: assert property (@(posedge clk) disable iff (rst)
        (per_cnt != '0) |-> !start_i);
    // R10: no frame starts inside the quiet gap
    p_quiet_gap_r10: assert property (@(posedge clk) disable iff (rst)
        (qt_cnt != '0) |-> !start_i);
endmodule

// File: rtl/adc2ch_reader.sv
module adc2ch_reader
    import adc2ch_pkg::*;
#(
    parameter int DIV_HALF   = 20,
    parameter int QUIET_CYC  = 6,
    parameter int PERIOD_CYC = 800
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             scan_i,
    input  logic             fixed_ch_i,
    input  logic             dout_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             din_o,
    output logic             valid_o,
    output logic             ch_o,
    output logic             lead_err_o,
    output logic [RES_W-1:0] code_o
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int FRAME_SYS = HALF_PERIODS * DIV_HALF;
    localparam int LW        = $clog2(FRAME_SYS + 2);

    phase_t      phase;
    logic        prev_sel;
    logic        next_sel;
    logic        start;
    logic        pace_ready;
    logic        fall;
    logic        rise;
    logic        last;
    logic        done;
    frame_word_t word;
    result_t     res;

    assign next_sel = pick_channel(scan_i, fixed_ch_i, prev_sel);
    assign start    = (phase == PH_IDLE) && run_i && pace_ready;
    assign res      = decode_frame(word);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            cs_n_o     <= 1'b1;
            prev_sel   <= 1'b0;
            valid_o    <= 1'b0;
            ch_o       <= 1'b0;
            lead_err_o <= 1'b0;
            code_o     <= '0;
        end else begin
            valid_o <= 1'b0;
            if (start) begin
                phase    <= PH_FRAME;
                cs_n_o   <= 1'b0;
                prev_sel <= next_sel;
            end else if ((phase == PH_FRAME) && done) begin
                phase      <= PH_IDLE;
                cs_n_o     <= 1'b1;
                valid_o    <= 1'b1;
                ch_o       <= res.chan;
                lead_err_o <= res.lead_err;
                code_o     <= res.code;
            end
        end
    end

    adc2ch_sclk_gen #(.DIV_HALF(DIV_HALF)) u_sclk (
        .clk    (clk),
        .rst    (rst),
        .en_i   (phase == PH_FRAME),
        .park_i (last),
        .sclk_o (sclk_o),
        .fall_o (fall),
        .rise_o (rise)
    );

    adc2ch_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .sel_i   (next_sel),
        .fall_i  (fall),
        .rise_i  (rise),
        .dout_i  (dout_i),
        .din_o   (din_o),
        .last_o  (last),
        .done_o  (done),
        .word_o  (word)
    );

    adc2ch_pacer #(.QUIET_CYC(QUIET_CYC), .PERIOD_CYC(PERIOD_CYC)) u_pace (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .end_i   (done),
        .ready_o (pace_ready)
    );

    // observation counters used only by the properties below
    logic [LW-1:0]        lo_cnt;
    logic [BIT_CNT_W-1:0] rise_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt    <= '0;
            rise_seen <= '0;
        end else begin
            lo_cnt <= cs_n_o ? '0 : lo_cnt + 1'b1;
            if (start)
                rise_seen <= '0;
            else if ($rose(sclk_o) && !cs_n_o)
                rise_seen <= rise_seen + 1'b1;
        end
    end

    p_frame_len_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n_o) |-> (lo_cnt == LW'(FRAME_SYS)));
    p_rise_count_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n_o) |-> (rise_seen == BIT_CNT_W'(FRAME_BITS)));
    p_idle_sclk_r1: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> sclk_o);
    p_setup_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_o) |-> sclk_o);
    p_din_idle_r5: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> !din_o);
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);
    p_valid_at_end_r8: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $rose(cs_n_o));
    p_hold_result_r8: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(code_o) && $stable(ch_o) && $stable(lead_err_o)));
endmodule

// File: tb/adc2ch_reader_tb.sv
module adc2ch_reader_tb;
    import adc2ch_pkg::*;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DIV       = 20;
    localparam int QUIET     = 6;
    localparam int PERIOD    = 800;
    localparam int FRAME_SYS = HALF_PERIODS * DIV;

    logic clk = 1'b0, rst = 1'b1, run = 1'b0, scan = 1'b0, fixed_ch = 1'b0, dout = 1'b1;
    logic cs_n, sclk, din, valid, ch, lead_err;
    logic [RES_W-1:0] code;

    adc2ch_reader #(.DIV_HALF(DIV), .QUIET_CYC(QUIET), .PERIOD_CYC(PERIOD)) u_dut (
        .clk(clk), .rst(rst), .run_i(run), .scan_i(scan), .fixed_ch_i(fixed_ch),
        .dout_i(dout), .cs_n_o(cs_n), .sclk_o(sclk), .din_o(din), .valid_o(valid),
        .ch_o(ch), .lead_err_o(lead_err), .code_o(code)
    );

    always #2.5 clk = ~clk;

    typedef struct { logic [RES_W-1:0] code; logic bad; } stim_t;
    typedef struct { logic chn; logic [RES_W-1:0] code; logic bad; } exp_t;
    stim_t stim_q[$];
    exp_t  exp_q[$];

    int n_chk = 0, n_fail = 0, cyc = 0, frames = 0, results = 0;
    logic run_e = 1'b0, scan_e = 1'b0, fixed_e = 1'b0;

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        run_e   <= run;
        scan_e  <= scan;
        fixed_e <= fixed_ch;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic push_sample(input logic [RES_W-1:0] c, input logic bad);
        stim_t s;
        s.code = c;
        s.bad  = bad;
        stim_q.push_back(s);
    endtask

    // converter model, timing monitor and result scoreboard
    logic prev_cs = 1'b1, prev_sclk = 1'b1, conv_ch = 1'b0;
    logic exp_prev = 1'b0, exp_sel = 1'b0, exp_scan = 1'b0, cap_sel = 1'b0;
    logic din_bad = 1'b0, held = 1'b0, have_prev = 1'b0, have_rise = 1'b0, have_res = 1'b0;
    logic [FRAME_BITS-1:0] word = '0;
    logic [RES_W-1:0] last_code = '0;
    int fk = 0, rk = 0, t_fall = 0, t_rise = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_cs && !cs_n) begin
                stim_t s;
                exp_t  e;
                frames++;
                if (have_prev) begin
                    chk(cyc - t_fall >= PERIOD, "R9", "start spacing min", cyc - t_fall, PERIOD);
                    if (held)
                        chk(cyc - t_fall == PERIOD, "R9", "start spacing", cyc - t_fall, PERIOD);
                end
                if (have_rise)
                    chk(cyc - t_rise >= QUIET, "R10", "quiet gap", cyc - t_rise, QUIET);
                if (have_res)
                    chk(code == last_code, "R8", "result hold", code, last_code);
                t_fall = cyc; have_prev = 1'b1; held = 1'b1;
                exp_scan = scan_e;
                exp_sel  = scan_e ? ~exp_prev : fixed_e;
                exp_prev = exp_sel;
                if (stim_q.size() > 0) s = stim_q.pop_front();
                else begin s.code = RES_W'($urandom); s.bad = 1'b0; end
                word = {s.bad ? 3'b010 : 3'b000, conv_ch, s.code};
                e.chn = conv_ch; e.code = s.code; e.bad = s.bad;
                exp_q.push_back(e);
                fk = 0; rk = 0; din_bad = 1'b0; cap_sel = 1'b0;
                dout = 1'b1;
            end else if (!cs_n) begin
                if (prev_sclk && !sclk) begin
                    if (fk == 0)
                        chk(cyc - t_fall == DIV, "R2", "select to first fall", cyc - t_fall, DIV);
                    if (fk < FRAME_BITS) dout = word[FRAME_BITS-1-fk];
                    fk++;
                end
                if (!prev_sclk && sclk) begin
                    if (rk == SEL_SLOT) cap_sel = din;
                    else if (din) din_bad = 1'b1;
                    rk++;
                end
            end
            if (!prev_cs && cs_n) begin
                chk(cyc - t_fall == FRAME_SYS, "R1", "select low length", cyc - t_fall, FRAME_SYS);
                chk(rk == FRAME_BITS, "R1", "rising edges", rk, FRAME_BITS);
                chk(cap_sel == exp_sel, exp_scan ? "R6" : "R7", "requested channel", cap_sel, exp_sel);
                chk(!din_bad, "R5", "request line outside slot", din_bad, 0);
                chk(valid == 1'b1, "R8", "strobe at select rise", valid, 1);
                conv_ch = cap_sel;
                t_rise = cyc; have_rise = 1'b1;
            end
            if (cs_n && prev_cs) dout = 1'($urandom); // R11: noise while deselected
            if (!run_e) held = 1'b0;
            if (valid) begin
                results++;
                if (exp_q.size() == 0) chk(1'b0, "R8", "unexpected strobe", 1, 0);
                else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(code == e.code, "R3", "result code", code, e.code);
                    chk(ch == e.chn, "R3", "channel bit", ch, e.chn);
                    chk(lead_err == e.bad, "R4", "leading bit flag", lead_err, e.bad);
                end
                last_code = code; have_res = 1'b1;
            end
            prev_cs = cs_n; prev_sclk = sclk;
        end
    end

    task automatic wait_results(input int n);
        for (int i = 0; i < n; i++) @(posedge valid);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b1, "R13", "select/clock in reset", {cs_n, sclk}, 3);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n == 1'b1, "R13", "select after reset", cs_n, 1);
        chk(sclk == 1'b1, "R13", "clock after reset", sclk, 1);
        chk(din == 1'b0 && valid == 1'b0, "R13", "request/strobe", {din, valid}, 0);
        chk(code == '0 && ch == 1'b0 && lead_err == 1'b0, "R13", "result regs", code, 0);
        repeat (300) @(negedge clk);
        chk(frames == 0, "R12", "frames while stopped", frames, 0);

        // scan mode over code corners
        push_sample(12'h000, 1'b0); push_sample(12'hFFF, 1'b0);
        push_sample(12'hAAA, 1'b0); push_sample(12'h555, 1'b0);
        push_sample(12'h800, 1'b0); push_sample(12'h001, 1'b0);
        push_sample(12'h7FF, 1'b0); push_sample(12'h123, 1'b0);
        scan = 1'b1; run = 1'b1;
        wait_results(8);

        // fixed channel 0, then 1 with a corrupted leading bit
        scan = 1'b0; fixed_ch = 1'b0;
        push_sample(12'h3C3, 1'b0); push_sample(12'hC3C, 1'b0);
        wait_results(4);
        fixed_ch = 1'b1;
        push_sample(12'h0F0, 1'b1); push_sample(12'hF0F, 1'b0);
        wait_results(4);

        // R7: flip the fixed channel mid-frame
        wait (!cs_n);
        repeat (100) @(negedge clk);
        fixed_ch = 1'b0;
        wait_results(3);
        scan = 1'b1;
        wait_results(3);

        // R12: stop while a frame is running
        wait (!cs_n);
        repeat (50) @(negedge clk);
        run = 1'b0;
        begin
            int r0, f0;
            r0 = results; f0 = frames;
            repeat (3000) @(negedge clk);
            chk(results == r0 + 1, "R12", "running frame completes", results - r0, 1);
            chk(frames == f0, "R12", "no new frame", frames - f0, 0);
        end
        chk(exp_q.size() == 0, "R8", "results outstanding", exp_q.size(), 0);
        chk(cs_n == 1'b1 && sclk == 1'b1, "R1", "idle lines", {cs_n, sclk}, 3);
        finish_run();
    end
endmodule